// File: doc/BRIEF.md
# Polarity-Normalizing Interrupt Mask Controller

This block sits between a group of peripheral interrupt sources and a parent interrupt controller that accepts only active-high level inputs. Each source line passes through a two-flop synchronizer. It can then be inverted by a per-line reverse-polarity bit, so that an active-low source arrives at the parent as active-high. A per-line mask bit then gates it, and the result drives one output per line toward the parent.

Software controls the block through a simple register bus. There are three banks of 16-bit words: mask, reverse polarity and end-of-interrupt. Each word carries 16 lines, and words follow one another at a 4-byte stride. The mask and polarity words are plain read/write state, so software can save the polarity setup before a power-down and write it back afterwards. A 1 written to an end-of-interrupt bit gives a one-cycle acknowledge pulse on that line. The line count is a parameter of at most 64.

Top module: `irq_level_gate`

## Requirements
- R1: After reset every line is masked and no line is inverted. All parentIrq and eoiPulse bits are 0. Mask words read 1 for each existing line, and polarity words read 0.
- R2: A set mask bit forces that line's parentIrq low whatever its source level and polarity. A mask write takes effect on the outputs in the cycle that follows the write edge, and the written mask word reads back as written.
- R3: With a line unmasked and its polarity bit at 0, parentIrq follows srcIrq two clock edges after a source change.
- R4: With a line unmasked and its polarity bit at 1, parentIrq is the inverse of srcIrq, with the same two-edge latency.
- R5: Polarity words read back exactly the value last written, for every existing line bit.
- R6: Writing a 1 to an end-of-interrupt bit drives that line's eoiPulse high for exactly one cycle after the write edge. A 0 bit produces no pulse, and end-of-interrupt words always read 0.
- R7: Line n is bit n%16 of the word at bank base + (n/16)*4. The bank bases are 0x00 for mask, 0x10 for polarity and 0x20 for end-of-interrupt.
- R8: An access is ignored and reads 0 when it falls outside the three banks (0x30 and above), when it is not 4-byte aligned, or when it targets a word beyond the configured line count.
- R9: Word bits that correspond to lines at or above NUM_LINES read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register word |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from busAddr while busSel is high and busWr is low, 0 otherwise |
| srcIrq | input | NUM_LINES | Raw interrupt source levels |
| parentIrq | output | NUM_LINES | Active-high level interrupts to the parent controller |
| eoiPulse | output | NUM_LINES | One-cycle end-of-interrupt acknowledge per line |

## Verification
The bench builds the block with NUM_LINES = 20. With that value there is one full word and one partial word per bank, and two word slots in each bank are unused. This brings the unused high bits of the partial word and the out-of-range word addresses within reach, alongside the normal lines. At this size every line can be swept one at a time through both polarity settings and both source levels, with all other lines masked. Every line can also be pulsed through the end-of-interrupt bank, with the expected output vectors computed arithmetically from the written configuration.

// File: rtl/irq_level_gate_pkg.sv
`timescale 1ns/1ps
package irq_level_gate_pkg;
  localparam int MAX_LINES = 64;
  localparam int WORD_W    = 16;
  localparam int MAX_WORDS = MAX_LINES / WORD_W;
  localparam int WIDX_W    = $clog2(MAX_WORDS);

  localparam logic [1:0] BANK_MASK = 2'd0;
  localparam logic [1:0] BANK_POL  = 2'd1;
  localparam logic [1:0] BANK_EOI  = 2'd2;

  typedef struct packed {
    logic              maskWe;
    logic              polWe;
    logic              eoiWe;
    logic              rdMask;
    logic              rdPol;
    logic [WIDX_W-1:0] wordIdx;
  } strobe_t;
endpackage

// File: rtl/irq_level_gate_ctrl.sv
`timescale 1ns/1ps
module irq_level_gate_ctrl
  import irq_level_gate_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;

  logic              aligned, inSpan, wordOk, hit;
  logic [1:0]        bank;
  logic [WIDX_W-1:0] wordIdx;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    inSpan  = ((busAddr >> 6) == '0);
    bank    = busAddr[5:4];
    wordIdx = busAddr[3:2];
    wordOk  = (int'(wordIdx) < NUM_WORDS);
    hit     = busSel && aligned && inSpan && wordOk;
  end

  always_comb begin
    strb         = '0;
    strb.wordIdx = wordIdx;
    strb.maskWe  = hit &&  busWr && (bank == BANK_MASK);
    strb.polWe   = hit &&  busWr && (bank == BANK_POL);
    strb.eoiWe   = hit &&  busWr && (bank == BANK_EOI);
    strb.rdMask  = hit && !busWr && (bank == BANK_MASK);
    strb.rdPol   = hit && !busWr && (bank == BANK_POL);
  end

  // R7: at most one bank is selected per access
  p_bank_onehot_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.maskWe, strb.polWe, strb.eoiWe, strb.rdMask, strb.rdPol}));

  // R8: misaligned or beyond-bank accesses raise no strobe
  p_oor_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && ((busAddr[1:0] != 2'b00) || (busAddr >= ADDR_W'(48))))
    |-> !(strb.maskWe || strb.polWe || strb.eoiWe || strb.rdMask || strb.rdPol));
endmodule

// File: rtl/irq_level_gate_dp.sv
`timescale 1ns/1ps
module irq_level_gate_dp
  import irq_level_gate_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] srcIrq,
  output logic [NUM_LINES-1:0] parentIrq,
  output logic [NUM_LINES-1:0] eoiPulse,
  output logic [WORD_W-1:0]    rdata
);
  localparam int NUM_WORDS = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int PAD_W     = NUM_WORDS * WORD_W;

  logic [NUM_LINES-1:0] maskReg, polReg, eoiReg;
  logic [NUM_LINES-1:0] maskNext, polNext, eoiNext;
  logic [NUM_LINES-1:0] syncA, syncB;
  logic [PAD_W-1:0]     maskPad, polPad;

  // per-line write decode
  always_comb begin
    for (int n = 0; n < NUM_LINES; n++) begin
      logic lineSel;
      logic wBit;
      lineSel     = (strb.wordIdx == WIDX_W'(n / WORD_W));
      wBit        = wdata[n % WORD_W];
      maskNext[n] = (strb.maskWe && lineSel) ? wBit : maskReg[n];
      polNext[n]  = (strb.polWe  && lineSel) ? wBit : polReg[n];
      eoiNext[n]  = strb.eoiWe && lineSel && wBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '1;
      polReg  <= '0;
      eoiReg  <= '0;
      syncA   <= '0;
      syncB   <= '0;
    end else begin
      maskReg <= maskNext;
      polReg  <= polNext;
      eoiReg  <= eoiNext;
      syncA   <= srcIrq;
      syncB   <= syncA;
    end
  end

  assign parentIrq = (syncB ^ polReg) & ~maskReg;
  assign eoiPulse  = eoiReg;

  // readback, unused high bits read zero
  always_comb begin
    maskPad = '0;
    polPad  = '0;
    maskPad[NUM_LINES-1:0] = maskReg;
    polPad[NUM_LINES-1:0]  = polReg;
    rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strb.wordIdx == WIDX_W'(w)) begin
        if (strb.rdMask) rdata = maskPad[w*WORD_W +: WORD_W];
        if (strb.rdPol)  rdata = polPad[w*WORD_W +: WORD_W];
      end
    end
  end

  // R2: mask state changes only on a mask write strobe
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.maskWe) |-> $stable(maskReg));

  // R5: polarity state changes only on a polarity write strobe
  p_pol_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.polWe) |-> $stable(polReg));

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam logic [WIDX_W-1:0] WSEL = WIDX_W'(n / WORD_W);
    localparam int                BPOS = n % WORD_W;

    // R6: a written 1 yields a pulse on the next cycle
    p_eoi_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
      (strb.eoiWe && strb.wordIdx == WSEL && wdata[BPOS]) |=> eoiPulse[n]);

    // R6: no pulse without a write to this line's word
    p_eoi_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.eoiWe && strb.wordIdx == WSEL) |=> !eoiPulse[n]);
  end
endmodule

// File: rtl/irq_level_gate.sv
`timescale 1ns/1ps
module irq_level_gate
  import irq_level_gate_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [15:0]          busWdata,
  output logic [15:0]          busRdata,
  input  logic [NUM_LINES-1:0] srcIrq,
  output logic [NUM_LINES-1:0] parentIrq,
  output logic [NUM_LINES-1:0] eoiPulse
);
  strobe_t strb;

  irq_level_gate_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .strb(strb)
  );

  irq_level_gate_dp #(.NUM_LINES(NUM_LINES)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata),
    .srcIrq(srcIrq), .parentIrq(parentIrq), .eoiPulse(eoiPulse),
    .rdata(busRdata)
  );
endmodule

// File: tb/test_irq_level_gate.sv
`timescale 1ns/1ps
module test_irq_level_gate;
  localparam int NL = 20;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busSel, busWr;
  logic [7:0]    busAddr;
  logic [15:0]   busWdata, busRdata;
  logic [NL-1:0] srcIrq, parentIrq, eoiPulse;
  logic [NL-1:0] expMask, expPol;
  int nTests = 0;
  int nFail  = 0;

  always #4 clk = ~clk;

  irq_level_gate #(.NUM_LINES(NL), .ADDR_W(8)) i_irq_level_gate (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcIrq(srcIrq),
    .parentIrq(parentIrq), .eoiPulse(eoiPulse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic setCfg(input logic [NL-1:0] m, input logic [NL-1:0] p);
    busWrite(8'h00, m[15:0]);
    busWrite(8'h04, {12'h000, m[19:16]});
    busWrite(8'h10, p[15:0]);
    busWrite(8'h14, {12'h000, p[19:16]});
    expMask = m;
    expPol  = p;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic logic [NL-1:0] expOut(input logic [NL-1:0] s);
    return (s ^ expPol) & ~expMask;
  endfunction

  initial begin
    #(8 * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    rstN = 1'b0; busSel = 1'b0; busWr = 1'b0; busAddr = '0; busWdata = '0;
    srcIrq = '0;
    repeat (3) @(negedge clk);
    srcIrq = '1;
    rstN = 1'b1;
    settle();

    // R1 reset state
    check("R1 outputs", {12'h0, parentIrq}, 32'h0);
    check("R1 eoi", {12'h0, eoiPulse}, 32'h0);
    busRead(8'h00, rd); check("R1 mask word0", {16'h0, rd}, 32'hFFFF);
    busRead(8'h04, rd); check("R1 R9 mask word1", {16'h0, rd}, 32'h000F);
    busRead(8'h10, rd); check("R1 pol word0", {16'h0, rd}, 32'h0);
    busRead(8'h14, rd); check("R1 pol word1", {16'h0, rd}, 32'h0);

    // R3 R4 R7: per-line sweep, all other lines masked
    for (int n = 0; n < NL; n++) begin
      for (int p = 0; p < 2; p++) begin
        setCfg(~(NL'(1) << n), p[0] ? (NL'(1) << n) : NL'(0));
        for (int s = 0; s < 2; s++) begin
          srcIrq = s[0] ? '1 : '0;
          settle();
          check(p[0] ? "R4 R7 inverted line" : "R3 R7 direct line",
                {12'h0, parentIrq}, {12'h0, expOut(srcIrq)});
        end
      end
    end

    // R2: all masked forces low
    setCfg('1, 20'h5A5A5);
    srcIrq = 20'h0F0F0;
    settle();
    check("R2 all masked", {12'h0, parentIrq}, 32'h0);

    // R2: mask write effect in the cycle after the write edge
    setCfg('0, '0);
    srcIrq = '1;
    settle();
    check("R2 unmasked all", {12'h0, parentIrq}, 32'hFFFFF);
    busWrite(8'h00, 16'hFFFF);
    check("R2 mask word0 immediate", {12'h0, parentIrq}, 32'hF0000);
    busWrite(8'h00, 16'h1234);
    busRead(8'h00, rd); check("R2 mask readback", {16'h0, rd}, 32'h1234);
    busWrite(8'h04, 16'hFFFF);
    busRead(8'h04, rd); check("R9 mask high bits", {16'h0, rd}, 32'h000F);

    // R5: polarity save/restore readback
    for (int k = 0; k < 4; k++) begin
      logic [15:0] pat;
      pat = 16'hA5C3 ^ (16'h1111 * 16'(k));
      busWrite(8'h10, pat);
      busRead(8'h10, rd); check("R5 pol word0", {16'h0, rd}, {16'h0, pat});
      busWrite(8'h14, ~pat);
      busRead(8'h14, rd); check("R5 R9 pol word1", {16'h0, rd}, {28'h0, ~pat[3:0]});
    end

    // R6 R7: per-line end-of-interrupt pulse
    for (int n = 0; n < NL; n++) begin
      busWrite(8'h20 + 8'(4 * (n / 16)), 16'(1) << (n % 16));
      check("R6 R7 eoi pulse", {12'h0, eoiPulse}, {12'h0, NL'(1) << n});
      @(negedge clk); #1;
      check("R6 eoi one cycle", {12'h0, eoiPulse}, 32'h0);
    end
    busWrite(8'h24, 16'hFFFF);
    check("R6 R9 eoi word1", {12'h0, eoiPulse}, 32'hF0000);
    busWrite(8'h20, 16'h0000);
    check("R6 eoi zero write", {12'h0, eoiPulse}, 32'h0);
    busRead(8'h20, rd); check("R6 eoi reads zero", {16'h0, rd}, 32'h0);

    // R8: ignored accesses
    busWrite(8'h00, 16'hBEEF);
    busWrite(8'h02, 16'h0000);
    busWrite(8'h08, 16'h0000);
    busWrite(8'h30, 16'h0000);
    busWrite(8'h40, 16'h0000);
    busRead(8'h00, rd); check("R8 mask untouched", {16'h0, rd}, 32'hBEEF);
    busRead(8'h08, rd); check("R8 word beyond count", {16'h0, rd}, 32'h0);
    busRead(8'h18, rd); check("R8 pol word beyond count", {16'h0, rd}, 32'h0);
    busRead(8'h30, rd); check("R8 beyond banks", {16'h0, rd}, 32'h0);
    busRead(8'h02, rd); check("R8 misaligned", {16'h0, rd}, 32'h0);
    busWrite(8'h28, 16'hFFFF);
    check("R8 eoi beyond count", {12'h0, eoiPulse}, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule